// File: doc/BRIEF.md
# Differential Clock Output State Controller

This block chooses, for every differential clock pair of a clock generator, which of four drive states the analog output stage should take: running, parked at the strong stop level, parked at the weak power-down level, or tristate. The choice comes from the power-down input, the CPU stop pin, a stop request for the SRC group, and four configuration bits per pair: enable, power-down tristate, stop tristate and stoppable. The result is a 2-bit code per pair that a driver stage downstream turns into current levels.

One pin has two jobs. While the system comes up, its low level marks power-good. At that point the block latches a strap that decides whether the shared pair carries CPU2 or SRC7. Once power-good has been seen, the same pin acts as an active-high power-down request. The two asynchronous pins pass through synchronizers. Each pair changes state only on a strobe that marks a transition of that pair's own clock, so a stop or a resume never clips a half period. A stopped CPU pair resumes a fixed number of CPU transitions after the stop pin is released.

Top module: `diffclk_state_ctl`

## Requirements
- R1: The state codes are 2'b00 running, 2'b01 strong park (true high, complement low), 2'b10 weak park and 2'b11 tristate. After reset, and for as long as power-good has not been detected, every pair reports 2'b11.
- R2: A pair whose enable bit is 0 goes to 2'b11 at its next strobe, whatever the power-down, stop and stoppable settings are.
- R3: While power-down is active, an enabled pair goes to 2'b10 if its power-down tristate bit is 0, or to 2'b11 if that bit is 1. This holds for stoppable and non-stoppable pairs alike, and power-down overrides any stop that is in effect.
- R4: When the CPU stop pin is low and power-down is inactive, a CPU pair marked stoppable goes to 2'b01, or to 2'b11 if its stop tristate bit is 1. Non-stoppable CPU pairs stay at 2'b00.
- R5: A CPU stop takes effect only at the first CPU strobe after the pin has passed the two-flop synchronizer. Without a strobe, the pair keeps running.
- R6: After the synchronized release of the CPU stop pin, a stopped CPU pair returns to 2'b00 at the RESUME_EDGES-th CPU strobe (default 2) and not earlier.
- R7: While src_stop_req is high and power-down is inactive, an SRC pair marked stoppable goes to 2'b01, or to 2'b11 if src_stop_tri is 1. Non-stoppable SRC pairs stay at 2'b00. The SRC stop has no effect on CPU pairs.
- R8: The DOT96 pair runs unless it is disabled or power-down is active. The CPU stop and the SRC stop have no effect on it.
- R9: A pair's state code changes only at a clock edge where that pair's own strobe is high (cpu_edge, src_edge or dot_edge).
- R10: The strap value is latched at the edge where power-good is detected. It drives shared_is_cpu (1 selects CPU2, the top CPU index; 0 selects SRC7, the top SRC index). The shared pair then uses the configuration, stop source and strobe of the selected function. Later strap changes are ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrgd_pd_pin | input | 1 | Asynchronous; low marks power-good, afterwards high requests power-down |
| itp_strap | input | 1 | Shared-pair strap: 1 CPU2, 0 SRC7 |
| cpu_stop_pin_n | input | 1 | Asynchronous CPU stop, active low |
| src_stop_req | input | 1 | SRC stop request, active high, already in clk domain |
| cpu_edge | input | 1 | Strobe marking a CPU clock transition |
| src_edge | input | 1 | Strobe marking an SRC clock transition |
| dot_edge | input | 1 | Strobe marking a DOT96 clock transition |
| cpu_oe | input | NCPU | CPU pair enables, bit i for CPU i |
| cpu_pd_tri | input | NCPU | CPU power-down tristate bits |
| cpu_stop_tri | input | NCPU | CPU stop tristate bits |
| cpu_stoppable | input | NCPU | CPU pairs that obey the stop pin |
| src_oe | input | NSRC | SRC pair enables, bit j for SRC j+1 |
| src_pd_tri | input | 1 | SRC group power-down tristate |
| src_stop_tri | input | 1 | SRC group stop tristate |
| src_stoppable | input | NSRC | SRC pairs that obey the stop request |
| dot_oe | input | 1 | DOT96 enable |
| dot_pd_tri | input | 1 | DOT96 power-down tristate |
| shared_is_cpu | output | 1 | Latched strap: shared pair carries CPU2 |
| cpu_state | output | 2*(NCPU-1) | States of dedicated CPU pairs, CPU i at [2i+:2] |
| src_state | output | 2*(NSRC-1) | States of dedicated SRC pairs, SRC j+1 at [2j+:2] |
| shared_state | output | 2 | State of the CPU2/SRC7 pair |
| dot_state | output | 2 | State of the DOT96 pair |

## Verification
The bench holds back the CPU strobe while a stop is applied and while it is released. A design that parks as soon as the pin is synchronized, or that resumes one strobe early, shows the wrong code between strobes. It combines power-down with an active CPU stop and with a disabled pair, so a wrong priority order shows up as a strong park where a weak park or a tristate is expected. It changes the strap after power-good and resets into the SRC7 selection, which exposes a strap that is not latched or a shared pair wired to the wrong stop source. Pairs that are not stoppable are checked for staying in the running state during each stop.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_STRONG = 2'b01,
        ST_WEAK   = 2'b10,
        ST_TRI    = 2'b11
    } drv_e;

    typedef struct packed {
        logic oe;
        logic pd_tri;
        logic stop_tri;
        logic stoppable;
    } pair_cfg_t;

    // Priority: not live, disabled, power-down, stop, run.
    function automatic drv_e resolve(input logic live, input pair_cfg_t c,
                                     input logic pd, input logic stop);
        drv_e r;
        if (!live || !c.oe)            r = ST_TRI;
        else if (pd)                   r = c.pd_tri ? ST_TRI : ST_WEAK;
        else if (stop && c.stoppable)  r = c.stop_tri ? ST_TRI : ST_STRONG;
        else                           r = ST_RUN;
        return r;
    endfunction

endpackage

// File: rtl/dcs_sync.sv
module dcs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dcs_cpu_stop.sv
module dcs_cpu_stop #(
    parameter int RESUME_EDGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic stop_req,
    output logic stop_now
);
    localparam int CW = $clog2(RESUME_EDGES + 1);

    logic          stopped;
    logic [CW-1:0] cnt, cnt_next;

    always_comb begin
        stop_now = stopped;
        cnt_next = cnt;
        if (upd) begin
            if (stop_req) begin
                stop_now = 1'b1;
                cnt_next = '0;
            end else if (stopped) begin
                if (cnt == CW'(RESUME_EDGES - 1)) begin
                    stop_now = 1'b0;
                    cnt_next = '0;
                end else begin
                    cnt_next = cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stopped <= 1'b0;
            cnt     <= '0;
        end else begin
            stopped <= stop_now;
            cnt     <= cnt_next;
        end
    end

    // R5: without a CPU strobe the stop status holds
    a_r5_no_stop_without_edge: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(stopped));

    // R6: resume on the final counted strobe after release
    a_r6_resume_on_count: assert property (@(posedge clk) disable iff (rst)
        (upd && !stop_req && stopped && cnt == CW'(RESUME_EDGES - 1)) |=> !stopped);

    // R6: never resume before the count is reached
    a_r6_no_early_resume: assert property (@(posedge clk) disable iff (rst)
        (stopped && !(upd && cnt == CW'(RESUME_EDGES - 1))) |=> stopped);
endmodule

// File: rtl/dcs_pair.sv
module dcs_pair
    import dcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      upd,
    input  logic      live,
    input  pair_cfg_t cfg,
    input  logic      pd,
    input  logic      stop,
    output logic [1:0] state
);
    drv_e st;

    always_ff @(posedge clk) begin
        if (rst)      st <= ST_TRI;
        else if (upd) st <= resolve(live, cfg, pd, stop);
    end

    assign state = st;

    // R9: state only moves on the pair's own strobe
    a_r9_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(st));

    // R2: disabled pair tristates
    a_r2_disabled_tri: assert property (@(posedge clk) disable iff (rst)
        (upd && !cfg.oe) |=> st == ST_TRI);

    // R3: power-down beats stop
    a_r3_pd_weak: assert property (@(posedge clk) disable iff (rst)
        (upd && live && cfg.oe && pd && !cfg.pd_tri) |=> st == ST_WEAK);

    // R1: nothing but tristate before power-good
    a_r1_not_live_tri: assert property (@(posedge clk) disable iff (rst)
        (upd && !live) |=> st == ST_TRI);
endmodule

// File: rtl/diffclk_state_ctl.sv
module diffclk_state_ctl
    import dcs_pkg::*;
#(
    parameter int NCPU         = 3,
    parameter int NSRC         = 7,
    parameter int RESUME_EDGES = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pwrgd_pd_pin,
    input  logic                    itp_strap,
    input  logic                    cpu_stop_pin_n,
    input  logic                    src_stop_req,
    input  logic                    cpu_edge,
    input  logic                    src_edge,
    input  logic                    dot_edge,
    input  logic [NCPU-1:0]         cpu_oe,
    input  logic [NCPU-1:0]         cpu_pd_tri,
    input  logic [NCPU-1:0]         cpu_stop_tri,
    input  logic [NCPU-1:0]         cpu_stoppable,
    input  logic [NSRC-1:0]         src_oe,
    input  logic                    src_pd_tri,
    input  logic                    src_stop_tri,
    input  logic [NSRC-1:0]         src_stoppable,
    input  logic                    dot_oe,
    input  logic                    dot_pd_tri,
    output logic                    shared_is_cpu,
    output logic [2*(NCPU-1)-1:0]   cpu_state,
    output logic [2*(NSRC-1)-1:0]   src_state,
    output logic [1:0]              shared_state,
    output logic [1:0]              dot_state
);
    localparam int NCPU_DED = NCPU - 1;
    localparam int NSRC_DED = NSRC - 1;

    logic pin_s, cpu_stop_s;
    logic pgood_seen, sel_cpu;
    logic pd, cpu_stop_now;

    dcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pg (
        .clk(clk), .rst(rst), .d(pwrgd_pd_pin), .q(pin_s));

    dcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stop (
        .clk(clk), .rst(rst), .d(cpu_stop_pin_n), .q(cpu_stop_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            pgood_seen <= 1'b0;
            sel_cpu    <= 1'b0;
        end else if (!pgood_seen && !pin_s) begin
            pgood_seen <= 1'b1;
            sel_cpu    <= itp_strap;
        end
    end

    assign pd            = pgood_seen & pin_s;
    assign shared_is_cpu = sel_cpu;

    dcs_cpu_stop #(.RESUME_EDGES(RESUME_EDGES)) u_cpu_stop (
        .clk(clk), .rst(rst), .upd(cpu_edge),
        .stop_req(~cpu_stop_s), .stop_now(cpu_stop_now));

    pair_cfg_t cpu_cfg [NCPU];
    pair_cfg_t src_cfg [NSRC];

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu_cfg
        assign cpu_cfg[i] = '{oe: cpu_oe[i], pd_tri: cpu_pd_tri[i],
                              stop_tri: cpu_stop_tri[i], stoppable: cpu_stoppable[i]};
    end
    for (genvar j = 0; j < NSRC; j++) begin : g_src_cfg
        assign src_cfg[j] = '{oe: src_oe[j], pd_tri: src_pd_tri,
                              stop_tri: src_stop_tri, stoppable: src_stoppable[j]};
    end

    for (genvar i = 0; i < NCPU_DED; i++) begin : g_cpu
        dcs_pair u_pair (
            .clk(clk), .rst(rst), .upd(cpu_edge), .live(pgood_seen),
            .cfg(cpu_cfg[i]), .pd(pd), .stop(cpu_stop_now),
            .state(cpu_state[2*i +: 2]));
    end

    for (genvar j = 0; j < NSRC_DED; j++) begin : g_src
        dcs_pair u_pair (
            .clk(clk), .rst(rst), .upd(src_edge), .live(pgood_seen),
            .cfg(src_cfg[j]), .pd(pd), .stop(src_stop_req),
            .state(src_state[2*j +: 2]));
    end

    pair_cfg_t sh_cfg;
    logic      sh_upd, sh_stop;

    always_comb begin
        if (sel_cpu) begin
            sh_cfg  = cpu_cfg[NCPU-1];
            sh_upd  = cpu_edge;
            sh_stop = cpu_stop_now;
        end else begin
            sh_cfg  = src_cfg[NSRC-1];
            sh_upd  = src_edge;
            sh_stop = src_stop_req;
        end
    end

    dcs_pair u_shared (
        .clk(clk), .rst(rst), .upd(sh_upd), .live(pgood_seen),
        .cfg(sh_cfg), .pd(pd), .stop(sh_stop), .state(shared_state));

    pair_cfg_t dot_cfg;
    assign dot_cfg = '{oe: dot_oe, pd_tri: dot_pd_tri, stop_tri: 1'b0, stoppable: 1'b0};

    dcs_pair u_dot (
        .clk(clk), .rst(rst), .upd(dot_edge), .live(pgood_seen),
        .cfg(dot_cfg), .pd(pd), .stop(1'b0), .state(dot_state));

    // R10: strap selection frozen once power-good is seen
    a_r10_strap_hold: assert property (@(posedge clk) disable iff (rst)
        pgood_seen |=> ($stable(shared_is_cpu) && pgood_seen));

    // R1: no output leaves tristate before power-good
    a_r1_pre_pgood_tri: assert property (@(posedge clk) disable iff (rst)
        !pgood_seen |-> (dot_state == 2'b11 && shared_state == 2'b11));

    // R8: DOT96 never parks at the strong level
    a_r8_dot_never_strong: assert property (@(posedge clk) disable iff (rst)
        dot_state != 2'b01);
endmodule

// File: tb/test_diffclk_state_ctl.sv
module test_diffclk_state_ctl;
    localparam int NCPU = 3;
    localparam int NSRC = 7;
    localparam logic [1:0] RUN = 2'b00, STR = 2'b01, WK = 2'b10, TRI = 2'b11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwrgd_pd_pin = 1'b1, itp_strap = 1'b1, cpu_stop_pin_n = 1'b1, src_stop_req = 1'b0;
    logic cpu_edge = 1'b1, src_edge = 1'b1, dot_edge = 1'b1;
    logic [NCPU-1:0] cpu_oe = '1, cpu_pd_tri = '0, cpu_stop_tri = '0, cpu_stoppable = '1;
    logic [NSRC-1:0] src_oe = '1, src_stoppable = '0;
    logic src_pd_tri = 1'b0, src_stop_tri = 1'b0, dot_oe = 1'b1, dot_pd_tri = 1'b0;
    logic shared_is_cpu;
    logic [2*(NCPU-1)-1:0] cpu_state;
    logic [2*(NSRC-1)-1:0] src_state;
    logic [1:0] shared_state, dot_state;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    diffclk_state_ctl #(.NCPU(NCPU), .NSRC(NSRC)) i_diffclk_state_ctl (.*);

    task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        rst = 1'b1; pwrgd_pd_pin = 1'b1; itp_strap = strap;
        cpu_stop_pin_n = 1'b1; src_stop_req = 1'b0;
        cpu_oe = '1; cpu_pd_tri = '0; cpu_stop_tri = '0; cpu_stoppable = '1;
        src_oe = '1; src_stoppable = '0; src_pd_tri = 1'b0; src_stop_tri = 1'b0;
        dot_oe = 1'b1; dot_pd_tri = 1'b0;
        step(3);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        step(1);
        chk("R1", "cpu0 after reset", cpu_state[1:0], TRI);
        chk("R1", "dot after reset", dot_state, TRI);
        step(6);
        chk("R1", "src1 before power-good", src_state[1:0], TRI);
        chk("R1", "shared before power-good", shared_state, TRI);
    endtask

    task automatic t_pgood;
        pwrgd_pd_pin = 1'b0;
        step(6);
        chk("R10", "strap latched high", {1'b0, shared_is_cpu}, 2'b01);
        chk("R1", "cpu1 running", cpu_state[3:2], RUN);
        chk("R1", "dot running", dot_state, RUN);
        itp_strap = 1'b0;
        step(6);
        chk("R10", "strap change ignored", {1'b0, shared_is_cpu}, 2'b01);
    endtask

    task automatic t_oe;
        cpu_oe[1] = 1'b0;
        step(3);
        chk("R2", "cpu1 disabled", cpu_state[3:2], TRI);
        chk("R2", "cpu0 still running", cpu_state[1:0], RUN);
        cpu_oe[1] = 1'b1;
        step(3);
        chk("R2", "cpu1 re-enabled", cpu_state[3:2], RUN);
    endtask

    task automatic t_cpu_stop;
        cpu_stop_pin_n = 1'b0;
        step(6);
        chk("R4", "cpu0 strong park", cpu_state[1:0], STR);
        chk("R4", "shared CPU2 strong park", shared_state, STR);
        chk("R7", "src1 ignores CPU stop", src_state[1:0], RUN);
        chk("R8", "dot ignores CPU stop", dot_state, RUN);
        cpu_stop_tri[1] = 1'b1;
        cpu_stoppable[0] = 1'b0;
        step(3);
        chk("R4", "cpu1 stop tristate", cpu_state[3:2], TRI);
        chk("R4", "cpu0 non-stoppable runs", cpu_state[1:0], RUN);
        cpu_stop_pin_n = 1'b1;
        cpu_stop_tri = '0; cpu_stoppable = '1;
        step(8);
        chk("R6", "cpu1 running after release", cpu_state[3:2], RUN);
    endtask

    task automatic t_stop_timing;
        cpu_edge = 1'b0;
        cpu_stop_pin_n = 1'b0;
        step(5);
        chk("R5", "no park without strobe", cpu_state[1:0], RUN);
        chk("R9", "shared holds without strobe", shared_state, RUN);
        cpu_edge = 1'b1; step(1); cpu_edge = 1'b0;
        chk("R5", "park at first strobe", cpu_state[1:0], STR);
        cpu_stop_pin_n = 1'b1;
        step(5);
        chk("R9", "still parked, no strobe", cpu_state[1:0], STR);
        cpu_edge = 1'b1; step(1); cpu_edge = 1'b0;
        chk("R6", "parked after 1st strobe", cpu_state[1:0], STR);
        cpu_edge = 1'b1; step(1); cpu_edge = 1'b0;
        chk("R6", "running after 2nd strobe", cpu_state[1:0], RUN);
        cpu_edge = 1'b1;
        step(2);
    endtask

    task automatic t_src_stop;
        src_stoppable[2] = 1'b1;
        src_edge = 1'b0;
        src_stop_req = 1'b1;
        step(3);
        chk("R9", "src3 holds without strobe", src_state[5:4], RUN);
        src_edge = 1'b1;
        step(2);
        chk("R7", "src3 strong park", src_state[5:4], STR);
        chk("R7", "src1 non-stoppable runs", src_state[1:0], RUN);
        chk("R7", "shared CPU2 ignores SRC stop", shared_state, RUN);
        src_stop_tri = 1'b1;
        step(2);
        chk("R7", "src3 stop tristate", src_state[5:4], TRI);
        src_stop_req = 1'b0; src_stop_tri = 1'b0; src_stoppable = '0;
        step(2);
    endtask

    task automatic t_pd;
        cpu_stop_pin_n = 1'b0;
        cpu_pd_tri[0] = 1'b1;
        cpu_oe[2] = 1'b0;
        pwrgd_pd_pin = 1'b1;
        step(6);
        chk("R3", "cpu0 pd tristate", cpu_state[1:0], TRI);
        chk("R3", "cpu1 weak over stop", cpu_state[3:2], WK);
        chk("R2", "disabled CPU2 stays tristate in pd", shared_state, TRI);
        chk("R3", "src1 weak", src_state[1:0], WK);
        chk("R8", "dot weak in pd", dot_state, WK);
        dot_pd_tri = 1'b1;
        step(2);
        chk("R8", "dot tristate in pd", dot_state, TRI);
        pwrgd_pd_pin = 1'b0; cpu_stop_pin_n = 1'b1;
        cpu_pd_tri = '0; cpu_oe = '1; dot_pd_tri = 1'b0;
        step(10);
        chk("R3", "cpu1 running after pd", cpu_state[3:2], RUN);
        chk("R8", "dot running after pd", dot_state, RUN);
    endtask

    task automatic t_shared_src;
        do_reset(1'b0);
        pwrgd_pd_pin = 1'b0;
        step(6);
        chk("R10", "strap latched low", {1'b0, shared_is_cpu}, 2'b00);
        chk("R10", "shared SRC7 running", shared_state, RUN);
        cpu_stop_pin_n = 1'b0;
        step(6);
        chk("R10", "SRC7 ignores CPU stop", shared_state, RUN);
        cpu_stop_pin_n = 1'b1;
        src_stoppable[NSRC-1] = 1'b1;
        src_stop_req = 1'b1;
        step(3);
        chk("R10", "SRC7 parks on SRC stop", shared_state, STR);
    endtask

    initial begin
        do_reset(1'b1);
        t_reset();
        t_pgood();
        t_oe();
        t_cpu_stop();
        t_stop_timing();
        t_src_stop();
        t_pd();
        t_shared_src();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule